// File: doc/BRIEF.md
# Six-Field Range Flow Classifier

This block assigns each parsed packet header to a flow number by testing it against a small table of classification rules. A header carries six fields: a 32-bit source address, a 32-bit destination address, a 16-bit source port, a 16-bit destination port, an 8-bit service-class byte and an 8-bit protocol number. Each rule holds an inclusive low and high bound for every one of those fields, plus an enable bit. A header belongs to a rule only when all six of its fields fall inside that rule's bounds.

Headers arrive on a valid/ready handshake. All rules are evaluated in parallel in the cycle of acceptance, and the result is registered. The result gives the index of the lowest-numbered matching rule as the flow number, together with a match flag. A downstream scheduler uses that flow number to pick a queue. Rules are written one at a time through a write port. While a rule write is in progress, header intake stalls for that cycle.

Top module: `flow_range_classifier`

## Requirements
- R1: The header and both rule bounds use one 112-bit packing, from most to least significant: source address [111:80], destination address [79:48], source port [47:32], destination port [31:16], service byte [15:8], protocol [7:0].
- R2: A header matches an enabled rule when, for every field, low <= value <= high. Both bounds are themselves in range.
- R3: A rule whose enable bit is 0 never matches. Reset clears the enable bit of every rule.
- R4: A header is accepted on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` is high for exactly the cycle after each acceptance and low otherwise.
- R5: When several enabled rules match, `out_flow` is the lowest matching rule index and `out_match` is 1.
- R6: When no rule matches, `out_match` is 0 and `out_flow` is 0.
- R7: A rule in which any field's low bound exceeds its high bound never matches.
- R8: `in_ready` is low while `cfg_we` is high or reset is asserted. A rule written on one edge governs every header accepted on later edges.
- R9: After reset, `out_valid`, `out_match` and `out_flow` are 0. `out_match` and `out_flow` keep their values until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one rule this cycle |
| cfg_idx | input | IDX_W (3) | Rule slot to write |
| cfg_en | input | 1 | Enable bit of the written rule |
| cfg_lo | input | 112 | Low bounds, packed per R1 |
| cfg_hi | input | 112 | High bounds, packed per R1 |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header can be taken |
| in_hdr | input | 112 | Header tuple, packed per R1 |
| out_valid | output | 1 | Result strobe, one cycle per header |
| out_match | output | 1 | Some enabled rule matched |
| out_flow | output | IDX_W (3) | Winning rule index, 0 on a miss |

## Verification
Four properties are checked on every cycle:
- the result strobe tracks acceptance exactly one cycle later;
- a miss always reports flow 0;
- results hold steady between acceptances;
- the priority picker never names a rule with a lower-indexed hit below it, and no inverted-bound rule ever raises a hit.

Whether a reported flow is the right one for a given header, including the exact behaviour at field bounds, can only be shown by the bench. The same is true of whether enabling, disabling and rewriting rules takes effect on the right header.

// File: rtl/fcls_pkg.sv
package fcls_pkg;
  localparam int ADDR_W = 32;
  localparam int PORT_W = 16;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [PORT_W-1:0] src_port;
    logic [PORT_W-1:0] dst_port;
    logic [BYTE_W-1:0] svc;
    logic [BYTE_W-1:0] proto;
  } tuple_t;

  localparam int TUPLE_W = $bits(tuple_t);

  // inclusive span test, fields are zero-extended to 32 bits by the caller
  function automatic logic in_span(logic [31:0] v, logic [31:0] lo, logic [31:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // true when some field has its low bound above its high bound
  function automatic logic bounds_inverted(tuple_t lo, tuple_t hi);
    return (lo.src_addr > hi.src_addr) || (lo.dst_addr > hi.dst_addr) ||
           (lo.src_port > hi.src_port) || (lo.dst_port > hi.dst_port) ||
           (lo.svc > hi.svc) || (lo.proto > hi.proto);
  endfunction
endpackage

// File: rtl/fcls_rule_store.sv
module fcls_rule_store
  import fcls_pkg::*;
#(
  parameter int N_RULES = 8,
  localparam int IDX_W = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wen,
  input  tuple_t           wlo,
  input  tuple_t           whi,
  output logic             en_o [N_RULES],
  output tuple_t           lo_o [N_RULES],
  output tuple_t           hi_o [N_RULES]
);
  for (genvar r = 0; r < N_RULES; r++) begin : g_slot
    logic   en_q;
    tuple_t lo_q, hi_q;
    wire    sel = we && (widx == IDX_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0;
        lo_q <= '0;
        hi_q <= '0;
      end else if (sel) begin
        en_q <= wen;
        lo_q <= wlo;
        hi_q <= whi;
      end
    end
    assign en_o[r] = en_q;
    assign lo_o[r] = lo_q;
    assign hi_o[r] = hi_q;
  end
endmodule

// File: rtl/fcls_rule_match.sv
module fcls_rule_match
  import fcls_pkg::*;
(
  input  tuple_t pkt,
  input  logic   en,
  input  tuple_t lo,
  input  tuple_t hi,
  output logic   hit
);
  logic [5:0] f_ok;
  always_comb begin
    f_ok[0] = in_span(pkt.src_addr, lo.src_addr, hi.src_addr);
    f_ok[1] = in_span(pkt.dst_addr, lo.dst_addr, hi.dst_addr);
    f_ok[2] = in_span(32'(pkt.src_port), 32'(lo.src_port), 32'(hi.src_port));
    f_ok[3] = in_span(32'(pkt.dst_port), 32'(lo.dst_port), 32'(hi.dst_port));
    f_ok[4] = in_span(32'(pkt.svc), 32'(lo.svc), 32'(hi.svc));
    f_ok[5] = in_span(32'(pkt.proto), 32'(lo.proto), 32'(hi.proto));
  end
  assign hit = en && (&f_ok);
endmodule

// File: rtl/fcls_first_hit.sv
module fcls_first_hit #(
  parameter int N_RULES = 8,
  localparam int IDX_W = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RULES-1:0] hits,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = N_RULES - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
  assign any = |hits;

  // bits strictly below the picked index, used by the priority check
  logic [N_RULES-1:0] below_mask;
  assign below_mask = (N_RULES'(1) << idx) - N_RULES'(1);

  // R5: picked rule is a hit and no lower-indexed rule hit
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (hits[idx] && ((hits & below_mask) == '0)));
endmodule

// File: rtl/flow_range_classifier.sv
module flow_range_classifier
  import fcls_pkg::*;
#(
  parameter int N_RULES = 8,
  localparam int IDX_W = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_en,
  input  logic [TUPLE_W-1:0] cfg_lo,
  input  logic [TUPLE_W-1:0] cfg_hi,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TUPLE_W-1:0] in_hdr,
  output logic               out_valid,
  output logic               out_match,
  output logic [IDX_W-1:0]   out_flow
);
  logic   r_en [N_RULES];
  tuple_t r_lo [N_RULES];
  tuple_t r_hi [N_RULES];

  fcls_rule_store #(.N_RULES(N_RULES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_idx), .wen(cfg_en),
    .wlo(tuple_t'(cfg_lo)), .whi(tuple_t'(cfg_hi)),
    .en_o(r_en), .lo_o(r_lo), .hi_o(r_hi)
  );

  tuple_t pkt;
  assign pkt = tuple_t'(in_hdr);

  logic [N_RULES-1:0] hits;
  for (genvar r = 0; r < N_RULES; r++) begin : g_rule
    fcls_rule_match u_match (
      .pkt(pkt), .en(r_en[r]), .lo(r_lo[r]), .hi(r_hi[r]), .hit(hits[r])
    );
    // R7: inverted bounds never produce a hit
    a_r7_inverted_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      bounds_inverted(r_lo[r], r_hi[r]) |-> !hits[r]);
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  fcls_first_hit #(.N_RULES(N_RULES)) u_pick (
    .clk(clk), .rst_n(rst_n), .hits(hits), .any(any_hit), .idx(win_idx)
  );

  // handshake: rule writes take the cycle, headers wait
  assign in_ready = rst_n && !cfg_we;
  wire accept = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_match <= 1'b0;
      out_flow  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_match <= any_hit;
        out_flow  <= any_hit ? win_idx : '0;
      end
    end
  end

  // R4: one result strobe per accepted header, one cycle later
  a_r4_strobe_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(accept));
  // R6: a miss reports flow zero
  a_r6_miss_flow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_match |-> (out_flow == '0));
  // R8: no intake while a rule is being written
  a_r8_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !in_ready);
  // R9: result holds between acceptances
  a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(out_match) && $stable(out_flow)));
endmodule

// File: tb/flow_range_classifier_tb.sv
module flow_range_classifier_tb;
  import fcls_pkg::*;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0, in_valid = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [TUPLE_W-1:0] cfg_lo = '0, cfg_hi = '0, in_hdr = '0;
  logic in_ready, out_valid, out_match;
  logic [IW-1:0] out_flow;

  always #2 clk = ~clk;

  flow_range_classifier #(.N_RULES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .out_valid(out_valid), .out_match(out_match), .out_flow(out_flow)
  );

  int total = 0, fails = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1 packing: src_addr, dst_addr, src_port, dst_port, svc, proto
  localparam logic [TUPLE_W-1:0] FULL_LO = '0;
  localparam logic [TUPLE_W-1:0] FULL_HI = '1;

  typedef struct packed {
    logic [TUPLE_W-1:0] hdr;
    logic               m;
    logic [IW-1:0]      f;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{ {32'h0A000005, 32'h0, 16'd0, 16'd80, 8'h00, 8'd6}, 1'b1, 3'd1 }, // R5 r1 beats r2
    '{ {32'h0A000100, 32'h0, 16'd0, 16'd80, 8'h00, 8'd6}, 1'b1, 3'd2 }, // R2 just above r1
    '{ {32'h0A000000, 32'h0, 16'd0, 16'd0,  8'h00, 8'd6}, 1'b1, 3'd1 }, // R2 low bound
    '{ {32'h0A0000FF, 32'h0, 16'd0, 16'd81, 8'h20, 8'd7}, 1'b0, 3'd0 }, // R6 miss
    '{ {32'h0,        32'h0, 16'd0, 16'd0,  8'h10, 8'd0}, 1'b1, 3'd3 }, // R2 svc low
    '{ {32'h0,        32'h0, 16'd0, 16'd80, 8'h1F, 8'd0}, 1'b1, 3'd2 }, // R5 r2 beats r3
    '{ {32'h0,        32'h0, 16'd75, 16'd0, 8'h00, 8'd0}, 1'b0, 3'd0 }, // R7 inverted r4
    '{ {32'h0, 32'hC0A80001, 16'd2000, 16'd0, 8'h00, 8'd0}, 1'b1, 3'd5 }, // R2 high bound
    '{ {32'h0, 32'hC0A80001, 16'd2001, 16'd0, 8'h00, 8'd0}, 1'b0, 3'd0 }, // R6 above
    '{ {32'h0, 32'hC0A80002, 16'd1000, 16'd0, 8'h00, 8'd0}, 1'b0, 3'd0 }  // R6 one field out
  };

  task automatic wr_rule(int idx, logic en, logic [TUPLE_W-1:0] lo, logic [TUPLE_W-1:0] hi);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_en = en; cfg_lo = lo; cfg_hi = hi;
    in_valid = 1;
    #1 check("R8 ready low during write", 32'(in_ready), 32'd0);
    @(posedge clk);
    #1 check("R8 no result while stalled", 32'(out_valid), 32'd0);
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
  endtask

  task automatic send(logic [TUPLE_W-1:0] h, logic em, logic [IW-1:0] ef, string tag);
    @(negedge clk);
    in_valid = 1; in_hdr = h;
    @(negedge clk);
    in_valid = 0;
    check({tag, " R4 out_valid"}, 32'(out_valid), 32'd1);
    check({tag, " match"}, 32'(out_match), 32'(em));
    check({tag, " flow"}, 32'(out_flow), 32'(ef));
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R9 reset state
    #1 check("R9 reset valid", 32'(out_valid), 0);
    check("R9 reset match", 32'(out_match), 0);
    check("R9 reset flow", 32'(out_flow), 0);
    check("R8 ready low in reset", 32'(in_ready), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check("R8 ready after reset", 32'(in_ready), 1);

    // R3: empty table after reset matches nothing
    send(VECS[0].hdr, 1'b0, 3'd0, "R3 empty table");

    wr_rule(0, 1'b0, FULL_LO, FULL_HI);
    wr_rule(1, 1'b1, {32'h0A000000, 32'h0, 16'h0, 16'h0, 8'h00, 8'd6},
                     {32'h0A0000FF, 32'hFFFFFFFF, 16'hFFFF, 16'hFFFF, 8'hFF, 8'd6});
    wr_rule(2, 1'b1, {32'h0, 32'h0, 16'h0, 16'd80, 8'h00, 8'h00},
                     {32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 16'd80, 8'hFF, 8'hFF});
    wr_rule(3, 1'b1, {32'h0, 32'h0, 16'h0, 16'h0, 8'h10, 8'h00},
                     {32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 16'hFFFF, 8'h1F, 8'hFF});
    wr_rule(4, 1'b1, {32'h0, 32'h0, 16'd100, 16'h0, 8'h00, 8'h00},
                     {32'hFFFFFFFF, 32'hFFFFFFFF, 16'd50, 16'hFFFF, 8'hFF, 8'hFF});
    wr_rule(5, 1'b1, {32'h0, 32'hC0A80001, 16'd1000, 16'h0, 8'h00, 8'h00},
                     {32'hFFFFFFFF, 32'hC0A80001, 16'd2000, 16'hFFFF, 8'hFF, 8'hFF});

    for (int i = 0; i < 10; i++) send(VECS[i].hdr, VECS[i].m, VECS[i].f, $sformatf("vec%0d", i));

    // R9: hold with no acceptance
    repeat (3) @(negedge clk);
    check("R4 idle valid low", 32'(out_valid), 0);
    check("R9 hold match", 32'(out_match), 0);
    check("R9 hold flow", 32'(out_flow), 0);

    // R4 back-to-back acceptances
    @(negedge clk); in_valid = 1; in_hdr = VECS[7].hdr;
    @(negedge clk); in_hdr = VECS[4].hdr;
    check("R4 b2b first", 32'(out_flow), 5);
    @(negedge clk); in_valid = 0;
    check("R4 b2b second", 32'(out_flow), 3);
    check("R4 b2b valid", 32'(out_valid), 1);

    // R3 / R8: enable rule 0, it wins everything; then disable it again
    wr_rule(0, 1'b1, FULL_LO, FULL_HI);
    send(VECS[3].hdr, 1'b1, 3'd0, "R8 rewrite takes effect");
    send(VECS[7].hdr, 1'b1, 3'd0, "R5 rule0 wins");
    wr_rule(0, 1'b0, FULL_LO, FULL_HI);
    send(VECS[3].hdr, 1'b0, 3'd0, "R3 disabled full rule");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule